// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block gathers up to 256 interrupt sources and holds each one in a pending bit. A pending bit is set only while the source is enabled. Each pending and enabled vector is steered to one or more of four cores and to one or more of eight parent interrupt lines per core. Every vector has its own route byte. The low nibble of that byte is a core mask and the high nibble is a node number. Only vectors whose node number matches the block's own `NODE_ID` parameter are delivered. Each group of 32 vectors shares one line-map byte, and bit k of that byte means the group raises parent line k.

Software reaches the block through a plain 32-bit register port with an address, write data, byte strobes and a combinational read-data output. Through this port it programs the enables, line maps and route bytes, and it reads and clears pending status. A build may expose fewer vectors than the storage holds, set by `ACTIVE_VEC`. Vectors at or above that limit hold nothing and never assert.

Top module: `eio_router`

## Requirements
- R1: After reset every enable, pending, line-map and route value reads as zero and all `irq_lines` are low. Register writes take effect at the next rising clock edge.
- R2: A source that is high at a clock edge while its enable bit is 1 sets its pending bit at that edge. Pending status is read as 32-bit words at byte address 0x040 + 4*(n/32), with vector n at bit n%32. This is the same as a 64-bit word n/64 at 0x040 + 8*(n/64), bit n%64.
- R3: A source whose enable bit is 0 never sets its pending bit.
- R4: Writing 1 to a pending-status bit clears it, and writing 0 leaves it unchanged. If a clear and a set of the same vector fall in one cycle, the set wins and the bit stays 1.
- R5: Enable bits are 32-bit words at byte address 0x000 + 4*(n>>5), with vector n at bit n&31. Reads return the stored value.
- R6: The route byte of vector n is byte n%4 (bits 8*(n%4)+7 : 8*(n%4)) of the word at 0x400 + 4*(n/4). Its bits [3:0] are a core mask, with bit c meaning core c. Its bits [7:4] are the target node.
- R7: The line-map byte of group g (vectors 32g..32g+31) is byte g%4 of the word at 0x080 + 4*(g/4). Its bit k selects parent line k.
- R8: `irq_lines[8*c+k]` is high in any cycle where some vector meets all of these conditions: it is pending and enabled, route bit c of its route byte is set, its node field equals `NODE_ID`, and bit k of its group's line map is set. The output follows the stored state with no added register.
- R9: A vector whose route node differs from `NODE_ID` drives no output, even while it is pending and enabled.
- R10: Vectors numbered `ACTIVE_VEC` or higher read as zero in the enable, pending and route registers, never become pending, and never drive an output.
- R11: Clearing an enable bit removes its vector from the outputs at the next edge but keeps the vector's pending bit.
- R12: A write changes only the bytes whose strobe bit in `reg_be` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_VEC | Interrupt source levels, one per vector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 11 | Byte address of the 32-bit register |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes for the write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_lines | output | 32 | Parent lines, bit 8*core+line |

## Verification
A source can set a pending bit in the same cycle that software writes 1 to clear that bit. The block must settle this with the set winning. The bench holds a source high on an enabled vector and issues a clear write in that same cycle. It then reads the status word and expects the bit still set. It then drops the source, issues a second clear, and expects the bit to read zero.

// File: rtl/eio_pkg.sv
package eio_pkg;

    localparam int ADDR_W = 11;
    localparam int CORES  = 4;
    localparam int LINES  = 8;

    // word addresses (byte address >> 2) of each table
    localparam logic [8:0] EN_WA   = 9'h000;
    localparam logic [8:0] STAT_WA = 9'h010;
    localparam logic [8:0] MAP_WA  = 9'h020;
    localparam logic [8:0] RT_WA   = 9'h100;

    typedef struct packed {
        logic [3:0] node;
        logic [3:0] cores;
    } route_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_EN,
        RG_STAT,
        RG_MAP,
        RG_ROUTE
    } region_e;

    // cores a route byte reaches on this node; empty for a foreign node
    function automatic logic [3:0] local_cores(input route_t r, input logic [3:0] node);
        return (r.node == node) ? r.cores : 4'b0000;
    endfunction

endpackage

// File: rtl/eio_cfg.sv
module eio_cfg
    import eio_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  region_e                   rg,
    input  logic [7:0]                off,
    input  logic [31:0]               wdata,
    input  logic [3:0]                be,
    input  logic [NUM_VEC-1:0]        valid,
    output logic [NUM_VEC-1:0]        en_vec,
    output logic [NUM_VEC/32-1:0][7:0] map_vec,
    output route_t [NUM_VEC-1:0]      route_vec
);
    localparam int EN_W  = NUM_VEC / 32;
    localparam int MAP_W = NUM_VEC / 128;
    localparam int RT_W  = NUM_VEC / 4;
    localparam int GROUPS = NUM_VEC / 32;

    logic [NUM_VEC-1:0]       en_q;
    logic [GROUPS-1:0][7:0]   map_q;
    route_t [NUM_VEC-1:0]     route_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            map_q   <= '0;
            route_q <= '0;
        end else if (we) begin
            for (int w = 0; w < EN_W; w++) begin
                for (int b = 0; b < 4; b++) begin
                    if (rg == RG_EN && off == 8'(w) && be[b])
                        en_q[w*32+b*8 +: 8] <= wdata[b*8 +: 8] & valid[w*32+b*8 +: 8];
                end
            end
            for (int w = 0; w < MAP_W; w++) begin
                for (int b = 0; b < 4; b++) begin
                    if (rg == RG_MAP && off == 8'(w) && be[b])
                        map_q[w*4+b] <= wdata[b*8 +: 8];
                end
            end
            for (int w = 0; w < RT_W; w++) begin
                for (int b = 0; b < 4; b++) begin
                    if (rg == RG_ROUTE && off == 8'(w) && be[b])
                        route_q[w*4+b] <= valid[w*4+b] ? route_t'(wdata[b*8 +: 8]) : route_t'(8'h00);
                end
            end
        end
    end

    assign en_vec    = en_q;
    assign map_vec   = map_q;
    assign route_vec = route_q;

endmodule

// File: rtl/eio_pending.sv
module eio_pending #(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] src,
    input  logic [NUM_VEC-1:0] en,
    input  logic [NUM_VEC-1:0] valid,
    input  logic [NUM_VEC-1:0] clr,
    output logic [NUM_VEC-1:0] pend
);
    logic [NUM_VEC-1:0] pend_q;

    // a set in the same cycle as a clear keeps the bit
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | (src & en & valid);
    end

    assign pend = pend_q;

endmodule

// File: rtl/eio_dispatch.sv
module eio_dispatch
    import eio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NODE_ID = 0
) (
    input  logic [NUM_VEC-1:0]         pend,
    input  logic [NUM_VEC-1:0]         en,
    input  logic [NUM_VEC/32-1:0][7:0] map_vec,
    input  route_t [NUM_VEC-1:0]       route_vec,
    output logic [CORES*LINES-1:0]     irq
);
    localparam logic [3:0] NODE = 4'(NODE_ID);

    logic [NUM_VEC-1:0]      live;
    logic [NUM_VEC-1:0][3:0] core_hit;

    assign live = pend & en;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign core_hit[v] = local_cores(route_vec[v], NODE);
    end

    for (genvar c = 0; c < CORES; c++) begin : g_core
        for (genvar k = 0; k < LINES; k++) begin : g_line
            logic [NUM_VEC-1:0] sel;
            for (genvar v = 0; v < NUM_VEC; v++) begin : g_sel
                assign sel[v] = live[v] & core_hit[v][c] & map_vec[v/32][k];
            end
            assign irq[c*LINES+k] = |sel;
        end
    end

endmodule

// File: rtl/eio_router.sv
module eio_router
    import eio_pkg::*;
#(
    parameter int NUM_VEC    = 256,
    parameter int ACTIVE_VEC = 256,
    parameter int NODE_ID    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] src_in,
    input  logic               reg_we,
    input  logic [10:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic [3:0]         reg_be,
    output logic [31:0]        reg_rdata,
    output logic [31:0]        irq_lines
);
    localparam int EN_W  = NUM_VEC / 32;
    localparam int MAP_W = NUM_VEC / 128;
    localparam int RT_W  = NUM_VEC / 4;

    logic [8:0]                 word_a;
    region_e                    rg;
    logic [7:0]                 off;
    logic [NUM_VEC-1:0]         valid;
    logic [NUM_VEC-1:0]         en_vec;
    logic [NUM_VEC-1:0]         pend_vec;
    logic [NUM_VEC-1:0]         clr_vec;
    logic [NUM_VEC/32-1:0][7:0] map_vec;
    route_t [NUM_VEC-1:0]       route_vec;

    assign word_a = reg_addr[10:2];

    always_comb begin
        rg  = RG_NONE;
        off = '0;
        if (word_a >= EN_WA && word_a < EN_WA + 9'(EN_W)) begin
            rg  = RG_EN;
            off = 8'(word_a - EN_WA);
        end else if (word_a >= STAT_WA && word_a < STAT_WA + 9'(EN_W)) begin
            rg  = RG_STAT;
            off = 8'(word_a - STAT_WA);
        end else if (word_a >= MAP_WA && word_a < MAP_WA + 9'(MAP_W)) begin
            rg  = RG_MAP;
            off = 8'(word_a - MAP_WA);
        end else if (word_a >= RT_WA && word_a < RT_WA + 9'(RT_W)) begin
            rg  = RG_ROUTE;
            off = 8'(word_a - RT_WA);
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign valid[v]   = (v < ACTIVE_VEC);
        assign clr_vec[v] = reg_we && rg == RG_STAT && off == 8'(v / 32)
                            && reg_be[(v % 32) / 8] && reg_wdata[v % 32];
    end

    eio_cfg #(.NUM_VEC(NUM_VEC)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .rg       (rg),
        .off      (off),
        .wdata    (reg_wdata),
        .be       (reg_be),
        .valid    (valid),
        .en_vec   (en_vec),
        .map_vec  (map_vec),
        .route_vec(route_vec)
    );

    eio_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .src  (src_in),
        .en   (en_vec),
        .valid(valid),
        .clr  (clr_vec),
        .pend (pend_vec)
    );

    eio_dispatch #(.NUM_VEC(NUM_VEC), .NODE_ID(NODE_ID)) u_disp (
        .pend     (pend_vec),
        .en       (en_vec),
        .map_vec  (map_vec),
        .route_vec(route_vec),
        .irq      (irq_lines)
    );

    always_comb begin
        reg_rdata = '0;
        case (rg)
            RG_EN: begin
                for (int w = 0; w < EN_W; w++)
                    if (off == 8'(w)) reg_rdata = en_vec[w*32 +: 32];
            end
            RG_STAT: begin
                for (int w = 0; w < EN_W; w++)
                    if (off == 8'(w)) reg_rdata = pend_vec[w*32 +: 32];
            end
            RG_MAP: begin
                for (int w = 0; w < MAP_W; w++)
                    if (off == 8'(w))
                        for (int b = 0; b < 4; b++) reg_rdata[b*8 +: 8] = map_vec[w*4+b];
            end
            RG_ROUTE: begin
                for (int w = 0; w < RT_W; w++)
                    if (off == 8'(w))
                        for (int b = 0; b < 4; b++) reg_rdata[b*8 +: 8] = route_vec[w*4+b];
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eio_router_chk.sv
module eio_router_chk #(
    parameter int NUM_VEC    = 256,
    parameter int ACTIVE_VEC = 256
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_VEC-1:0] src_in,
    input logic [NUM_VEC-1:0] en_vec,
    input logic [NUM_VEC-1:0] pend_vec,
    input logic [31:0]        irq_lines
);
    logic [NUM_VEC-1:0] valid;
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_valid
        assign valid[v] = (v < ACTIVE_VEC);
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_vec == '0 && en_vec == '0 && irq_lines == '0));

    p_armed_sets_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((($past(src_in) & $past(en_vec)) & ~pend_vec) == '0));

    p_no_unarmed_set_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend_vec & ~$past(pend_vec) & ~($past(src_in) & $past(en_vec))) == '0));

    p_idle_outputs_r8: assert property (@(posedge clk) disable iff (rst)
        ((pend_vec & en_vec) == '0) |-> (irq_lines == '0));

    p_high_vectors_r10: assert property (@(posedge clk) disable iff (rst)
        ((pend_vec | en_vec) & ~valid) == '0);

endmodule

bind eio_router eio_router_chk #(.NUM_VEC(NUM_VEC), .ACTIVE_VEC(ACTIVE_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .en_vec   (en_vec),
    .pend_vec (pend_vec),
    .irq_lines(irq_lines)
);

// File: tb/eio_router_bench.sv
module eio_router_bench;
    localparam int NV = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NV-1:0] src = '0;
    logic          we = 1'b0;
    logic [10:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    be = '0;
    logic [31:0]   rdata;
    logic [31:0]   irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eio_router #(.NUM_VEC(NV), .ACTIVE_VEC(128), .NODE_ID(2)) u_eio_router (
        .clk(clk), .rst(rst), .src_in(src), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_be(be), .reg_rdata(rdata), .irq_lines(irq)
    );

    function automatic logic [10:0] a_en(int w);    return 11'(w * 4);          endfunction
    function automatic logic [10:0] a_stat(int w);  return 11'(12'h040 + w * 4); endfunction
    function automatic logic [10:0] a_map(int w);   return 11'(12'h080 + w * 4); endfunction
    function automatic logic [10:0] a_rt(int w);    return 11'(12'h400 + w * 4); endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src = '0; we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        we = 1'b0; be = '0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        src[v] = 1'b1;
        @(negedge clk);
        src[v] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(a_en(0), d);    check("R1 enable word0", d, 32'h0);
        rd(a_stat(1), d);  check("R1 status word1", d, 32'h0);
        rd(a_map(0), d);   check("R1 map word0", d, 32'h0);
        rd(a_rt(9), d);    check("R1 route word9", d, 32'h0);
        check("R1 irq_lines", irq, 32'h0);
    endtask

    task automatic t_enable_bytes();
        logic [31:0] d;
        do_reset();
        wr(a_en(3), 32'hFFFF_FFFF, 4'b0010);
        rd(a_en(3), d);  check("R12 strobe byte1 only", d, 32'h0000_FF00);
        wr(a_en(3), 32'h1234_5678, 4'b1001);
        rd(a_en(3), d);  check("R5 enable word3 readback", d, 32'h1200_FF78);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        do_reset();
        wr(a_en(1), 32'h0000_0020, 4'b0001);   // vector 37 enabled
        pulse(37);
        rd(a_stat(1), d);  check("R2 vector37 pending", d, 32'h0000_0020);
        pulse(38);
        rd(a_stat(1), d);  check("R3 disabled vector38 stays clear", d, 32'h0000_0020);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        do_reset();
        wr(a_en(1), 32'h0000_0020, 4'b0001);
        pulse(37);
        wr(a_stat(1), 32'hFFFF_FFDF, 4'b1111);
        rd(a_stat(1), d);  check("R4 zero write keeps bit", d, 32'h0000_0020);
        wr(a_stat(1), 32'h0000_0020, 4'b1111);
        rd(a_stat(1), d);  check("R4 one write clears bit", d, 32'h0);
        // set and clear in the same cycle
        @(negedge clk);
        src[37] = 1'b1;
        wr(a_stat(1), 32'h0000_0020, 4'b0001);
        rd(a_stat(1), d);  check("R4 set wins over clear", d, 32'h0000_0020);
        src[37] = 1'b0;
        wr(a_stat(1), 32'h0000_0020, 4'b0001);
        rd(a_stat(1), d);  check("R4 clear after source drops", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        do_reset();
        wr(a_rt(9), 32'h0000_2400, 4'b0010);   // vector 37: node 2, core 2
        wr(a_map(0), 32'h0000_0800, 4'b0010);  // group 1: line 3
        rd(a_rt(9), d);   check("R6 route byte readback", d, 32'h0000_2400);
        rd(a_map(0), d);  check("R7 map byte readback", d, 32'h0000_0800);
        wr(a_en(1), 32'h0000_0020, 4'b0001);
        pulse(37);
        check("R8 core2 line3", irq, 32'h0008_0000);
        wr(a_rt(9), 32'h0000_2500, 4'b0010);
        check("R6 cores 0 and 2", irq, 32'h0008_0008);
        wr(a_map(0), 32'h0000_0900, 4'b0010);
        check("R7 lines 0 and 3", irq, 32'h0009_0009);
        wr(a_rt(9), 32'h0000_3500, 4'b0010);
        check("R9 foreign node silent", irq, 32'h0);
        rd(a_stat(1), d); check("R9 pending kept", d, 32'h0000_0020);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        wr(a_rt(9), 32'h0000_2400, 4'b0010);
        wr(a_map(0), 32'h0000_0800, 4'b0010);
        wr(a_en(1), 32'h0000_0020, 4'b0001);
        pulse(37);
        check("R11 line up before mask", irq, 32'h0008_0000);
        wr(a_en(1), 32'h0000_0000, 4'b0001);
        check("R11 masked vector silent", irq, 32'h0);
        rd(a_stat(1), d); check("R11 pending kept while masked", d, 32'h0000_0020);
        wr(a_en(1), 32'h0000_0020, 4'b0001);
        check("R11 unmask raises again", irq, 32'h0008_0000);
    endtask

    task automatic t_limit();
        logic [31:0] d;
        do_reset();
        wr(a_en(4), 32'hFFFF_FFFF, 4'b1111);
        rd(a_en(4), d);   check("R10 enable above limit", d, 32'h0);
        wr(a_rt(32), 32'h2424_2424, 4'b1111);
        rd(a_rt(32), d);  check("R10 route above limit", d, 32'h0);
        wr(a_map(1), 32'h0000_00FF, 4'b0001);
        pulse(130);
        rd(a_stat(4), d); check("R10 status above limit", d, 32'h0);
        check("R10 no output above limit", irq, 32'h0);
        wr(a_en(3), 32'h8000_0000, 4'b1000);
        rd(a_en(3), d);   check("R10 last legal vector enable", d, 32'h8000_0000);
    endtask

    initial begin
        t_reset();
        t_enable_bytes();
        t_pending();
        t_clear();
        t_route();
        t_mask();
        t_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule